// File: doc/BRIEF.md
# Profile RAM Segment Write Loader

This block sits between a serial-port bit engine and a profile RAM. When a serial frame opens with the RAM-write instruction byte, the loader converts the bits that follow into a burst of full-width RAM writes. The burst fills one segment of the RAM. The transfer does not carry its own length.

The segment comes from two profile-select inputs. They pick one of four segment descriptors, and each descriptor holds a first address and a last address. When the instruction byte completes, the loader latches the selected pair. It then assembles 32-bit words from the serial stream, most significant bit first. Each finished word is written to the next address, starting at the first address and ending after the word for the last address. Any further bits in the frame are ignored.

Once the burst starts, the loader raises a read-suspend flag that stops the RAM-driven output path. The flag stays up until an update strobe arrives outside an active burst. If the frame closes early, the unfinished word is dropped and the loader waits for the next instruction.

Top module: `prof_seg_loader`

## Requirements
- R1: After synchronous reset, ram_we, ram_waddr, ram_wdata and rd_suspend are all 0.
- R2: A serial bit is taken only in a cycle where frame and bit_vld are both high. Cycles without bit_vld between bits have no effect.
- R3: In a frame, the first 8 taken bits form the instruction byte, MSB first. Only the value 8'h89 starts a burst. Any other byte makes the loader ignore the rest of that frame, and no RAM write happens.
- R4: The segment is chosen by prof_sel, sampled in the cycle that takes the 8th instruction bit. Profile i uses seg_first[i*AW +: AW] as its first address and seg_last[i*AW +: AW] as its last address. Later changes to prof_sel or to the descriptors do not affect the running burst.
- R5: After the instruction, each group of 32 taken bits forms one word, MSB first. ram_we is high for exactly one cycle, in the cycle after the 32nd bit is taken, and ram_wdata holds the word in that cycle.
- R6: The first word is written to the first address and each later word to the previous address plus 1. The word at the last address ends the burst, so a segment takes (last − first + 1) words: for example 256 words for 256..511. Bits after that in the same frame produce no write.
- R7: rd_suspend rises in the cycle after the instruction byte is accepted. It stays high during the burst and through every write.
- R8: An io_update pulse clears rd_suspend in the following cycle, but only when no burst is in progress. An io_update during a burst has no effect.
- R9: If frame drops before the burst ends, the partly assembled word is discarded and produces no write. The next frame starts again with instruction decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame | input | 1 | Serial transfer active (chip select, active high) |
| bit_vld | input | 1 | A serial bit is present on bit_in this cycle |
| bit_in | input | 1 | Serial data bit |
| prof_sel | input | PSW (2) | Profile select |
| seg_first | input | NPROF*AW (40) | Packed first addresses of all profiles |
| seg_last | input | NPROF*AW (40) | Packed last addresses of all profiles |
| io_update | input | 1 | Update strobe that releases the read suspension |
| ram_we | output | 1 | One-cycle RAM write pulse |
| ram_waddr | output | AW (10) | RAM write address |
| ram_wdata | output | WW (32) | RAM write data |
| rd_suspend | output | 1 | RAM reads held off |

## Verification
The bench uses the default parameters: a 10-bit address space with four profiles and 32-bit words. These values allow a full 256-word segment at addresses 256..511 (8192 data bits), a one-word segment where the first and last addresses are equal, and a segment that ends at the top address 1023. Bit gaps, a frame cut off mid-word, a rejected instruction byte and profile changes during a burst are all run against a behavioural reference that is compared on every cycle.

// File: rtl/psl_pkg.sv
package psl_pkg;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_BURST = 2'd1,
    LD_SKIP  = 2'd2
  } ld_state_e;

  localparam logic [7:0] RAM_WR_INSTR = 8'h89;

endpackage

// File: rtl/psl_seg_pick.sv
module psl_seg_pick #(
  parameter int NPROF = 4,
  parameter int AW    = 10,
  localparam int PSW  = $clog2(NPROF)
) (
  input  logic [PSW-1:0]      prof_sel,
  input  logic [NPROF*AW-1:0] seg_first,
  input  logic [NPROF*AW-1:0] seg_last,
  output logic [AW-1:0]       first_addr,
  output logic [AW-1:0]       last_addr
);

  logic [AW-1:0] first_arr [NPROF];
  logic [AW-1:0] last_arr  [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_unpack
    assign first_arr[g] = seg_first[g*AW +: AW];
    assign last_arr[g]  = seg_last[g*AW +: AW];
  end

  assign first_addr = first_arr[prof_sel];
  assign last_addr  = last_arr[prof_sel];

endmodule

// File: rtl/psl_bit_asm.sv
module psl_bit_asm #(
  parameter int WW   = 32,
  localparam int CW  = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          clear,
  input  logic          bit_in,
  output logic [CW-1:0] cnt,
  output logic [WW-1:0] next_word
);

  logic [WW-2:0] sr;

  assign next_word = {sr, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      if (take) begin
        sr <= next_word[WW-2:0];
      end
      if (clear) begin
        cnt <= '0;
      end else if (take) begin
        cnt <= (cnt == CW'(WW-1)) ? '0 : cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/psl_addr_seq.sv
module psl_addr_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_first,
  input  logic [AW-1:0] load_last,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      last_q <= '0;
    end else if (load) begin
      addr   <= load_first;
      last_q <= load_last;
    end else if (step) begin
      addr   <= addr + 1'b1;
    end
  end

  assign at_end = (addr == last_q);

endmodule

// File: rtl/psl_fsm.sv
module psl_fsm
  import psl_pkg::*;
#(
  parameter int WW      = 32,
  parameter int INSTR_W = 8,
  localparam int CW     = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame,
  input  logic          take,
  input  logic [CW-1:0] cnt,
  input  logic          instr_hit,
  input  logic          at_end,
  input  logic          io_update,
  output logic          asm_take,
  output logic          clr_cnt,
  output logic          load_addr,
  output logic          step_addr,
  output logic          wr_fire,
  output logic          suspend
);

  ld_state_e state, state_nx;
  logic instr_done, word_done;

  assign instr_done = (state == LD_IDLE)  && take && (cnt == CW'(INSTR_W-1));
  assign word_done  = (state == LD_BURST) && take && (cnt == CW'(WW-1));
  assign asm_take   = take && (state != LD_SKIP);
  assign clr_cnt    = !frame || instr_done;
  assign load_addr  = instr_done && instr_hit;
  assign step_addr  = word_done && !at_end;
  assign wr_fire    = word_done;

  always_comb begin
    state_nx = state;
    if (!frame) begin
      state_nx = LD_IDLE;
    end else begin
      unique case (state)
        LD_IDLE:  if (instr_done) state_nx = instr_hit ? LD_BURST : LD_SKIP;
        LD_BURST: if (word_done && at_end) state_nx = LD_SKIP;
        LD_SKIP:  state_nx = LD_SKIP;
        default:  state_nx = LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LD_IDLE;
      suspend <= 1'b0;
    end else begin
      state <= state_nx;
      if (load_addr) begin
        suspend <= 1'b1;
      end else if (io_update && (state != LD_BURST)) begin
        suspend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prof_seg_loader.sv
module prof_seg_loader
  import psl_pkg::*;
#(
  parameter int NPROF   = 4,
  parameter int AW      = 10,
  parameter int WW      = 32,
  parameter int INSTR_W = 8,
  localparam int PSW    = $clog2(NPROF),
  localparam int CW     = $clog2(WW)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame,
  input  logic                bit_vld,
  input  logic                bit_in,
  input  logic [PSW-1:0]      prof_sel,
  input  logic [NPROF*AW-1:0] seg_first,
  input  logic [NPROF*AW-1:0] seg_last,
  input  logic                io_update,
  output logic                ram_we,
  output logic [AW-1:0]       ram_waddr,
  output logic [WW-1:0]       ram_wdata,
  output logic                rd_suspend
);

  logic          take;
  logic          asm_take, clr_cnt, load_addr, step_addr, wr_fire, at_end;
  logic [CW-1:0] cnt;
  logic [WW-1:0] next_word;
  logic [AW-1:0] first_addr, last_addr, addr;
  logic          instr_hit;

  assign take      = frame && bit_vld;
  assign instr_hit = (next_word[INSTR_W-1:0] == RAM_WR_INSTR);

  psl_seg_pick #(.NPROF(NPROF), .AW(AW)) u_pick (
    .prof_sel  (prof_sel),
    .seg_first (seg_first),
    .seg_last  (seg_last),
    .first_addr(first_addr),
    .last_addr (last_addr)
  );

  psl_bit_asm #(.WW(WW)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .take     (asm_take),
    .clear    (clr_cnt),
    .bit_in   (bit_in),
    .cnt      (cnt),
    .next_word(next_word)
  );

  psl_addr_seq #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (load_addr),
    .load_first(first_addr),
    .load_last (last_addr),
    .step      (step_addr),
    .addr      (addr),
    .at_end    (at_end)
  );

  psl_fsm #(.WW(WW), .INSTR_W(INSTR_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .frame    (frame),
    .take     (take),
    .cnt      (cnt),
    .instr_hit(instr_hit),
    .at_end   (at_end),
    .io_update(io_update),
    .asm_take (asm_take),
    .clr_cnt  (clr_cnt),
    .load_addr(load_addr),
    .step_addr(step_addr),
    .wr_fire  (wr_fire),
    .suspend  (rd_suspend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= wr_fire;
      if (wr_fire) begin
        ram_waddr <= addr;
        ram_wdata <= next_word;
      end
    end
  end

endmodule

// File: rtl/prof_seg_loader_chk.sv
module prof_seg_loader_chk (
  input logic clk,
  input logic rst,
  input logic frame,
  input logic bit_vld,
  input logic io_update,
  input logic ram_we,
  input logic rd_suspend
);

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  p_we_after_bit_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(frame && bit_vld));

  p_we_suspended_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> rd_suspend);

  p_suspend_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_suspend) |-> $past(frame && bit_vld));

  p_suspend_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_suspend) |-> $past(io_update));

endmodule

bind prof_seg_loader prof_seg_loader_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame     (frame),
  .bit_vld   (bit_vld),
  .io_update (io_update),
  .ram_we    (ram_we),
  .rd_suspend(rd_suspend)
);

// File: tb/prof_seg_loader_test.sv
module prof_seg_loader_test;

  localparam int NPROF = 4;
  localparam int AW    = 10;
  localparam int WW    = 32;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                frame = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, io_update = 1'b0;
  logic [1:0]          prof_sel = 2'd0;
  logic [NPROF*AW-1:0] seg_first, seg_last;
  logic                ram_we, rd_suspend;
  logic [AW-1:0]       ram_waddr;
  logic [WW-1:0]       ram_wdata;

  int total = 0, bad = 0;
  int n_wr = 0, first_wa = -1, last_wa = -1;

  always #10 clk = ~clk;

  prof_seg_loader #(.NPROF(NPROF), .AW(AW), .WW(WW), .INSTR_W(8)) uut (
    .clk(clk), .rst(rst), .frame(frame), .bit_vld(bit_vld), .bit_in(bit_in),
    .prof_sel(prof_sel), .seg_first(seg_first), .seg_last(seg_last),
    .io_update(io_update), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .rd_suspend(rd_suspend)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          m_phase = 0;   // 0 decode, 1 burst, 2 ignore
  int          m_n = 0, m_addr = 0, m_end = 0;
  logic [31:0] m_acc = '0;
  bit          e_we = 0, e_sus = 0, armed = 0;
  int          e_addr = 0;
  logic [31:0] e_data = '0;

  always @(posedge clk) begin
    int  prev;
    bit  set_now;
    if (rst) begin
      m_phase = 0; m_n = 0; e_we = 0; e_sus = 0; e_addr = 0; e_data = '0; m_acc = '0;
    end else begin
      prev = m_phase; set_now = 0; e_we = 0;
      if (!frame) begin
        m_phase = 0; m_n = 0;
      end else if (bit_vld && m_phase != 2) begin
        m_acc = {m_acc[30:0], bit_in};
        m_n++;
        if (m_phase == 0 && m_n == 8) begin
          m_n = 0;
          if (m_acc[7:0] == 8'h89) begin
            m_phase = 1;
            m_addr = int'(seg_first[prof_sel*AW +: AW]);
            m_end  = int'(seg_last[prof_sel*AW +: AW]);
            e_sus = 1; set_now = 1;
          end else m_phase = 2;
        end else if (m_phase == 1 && m_n == 32) begin
          m_n = 0; e_we = 1; e_addr = m_addr; e_data = m_acc;
          if (m_addr == m_end) m_phase = 2;
          else m_addr = (m_addr + 1) % (1 << AW);
        end
      end
      if (!set_now && io_update && prev != 1) e_sus = 0;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(ram_we == e_we, "R5 we", ram_we, e_we);
      if (e_we) begin
        chk(int'(ram_waddr) == e_addr, "R6 addr", ram_waddr, e_addr);
        chk(ram_wdata == e_data, "R5 data", ram_wdata, e_data);
      end
      chk(rd_suspend == e_sus, "R7/R8 suspend", rd_suspend, e_sus);
    end
    if (!rst && ram_we) begin
      if (n_wr == 0) first_wa = int'(ram_waddr);
      last_wa = int'(ram_waddr);
      n_wr++;
    end
  end

  task automatic send_bit(input bit b, input int gap);
    bit_vld = 1'b1; bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0; bit_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int i = 7; i >= 0; i--) send_bit(v[i], gap);
  endtask

  task automatic send_word(input logic [31:0] v, input int gap);
    for (int i = 31; i >= 0; i--) send_bit(v[i], gap);
  endtask

  task automatic open_frame;
    n_wr = 0; first_wa = -1; last_wa = -1;
    frame = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_frame;
    @(negedge clk);
    frame = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_update;
    io_update = 1'b1;
    @(negedge clk);
    io_update = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seg_first = {10'd1020, 10'd100, 10'd256, 10'd5};
    seg_last  = {10'd1023, 10'd100, 10'd511, 10'd7};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ram_we && ram_waddr == 0 && ram_wdata == 0 && !rd_suspend, "R1 reset",
        {ram_we, rd_suspend, ram_waddr}, 0);
    rst = 1'b0;
    armed = 1;
    @(negedge clk);

    // R3 wrong instruction: no writes, no suspension
    open_frame();
    send_byte(8'h8B, 0);
    send_word(32'hFFFF_FFFF, 0);
    send_word(32'h1234_5678, 0);
    close_frame();
    chk(n_wr == 0, "R3 rejected byte writes", n_wr, 0);
    chk(!rd_suspend, "R3 rejected byte suspend", rd_suspend, 0);

    // R2 R5 R6: profile 0, gapped bits, extra word ignored
    prof_sel = 2'd0;
    open_frame();
    send_byte(8'h89, 1);
    send_word(32'hA5A5_0001, 1);
    send_word(32'h0000_0002, 2);
    send_word(32'h8000_0003, 0);
    send_word(32'hDEAD_BEEF, 0);
    close_frame();
    chk(n_wr == 3, "R6 count prof0", n_wr, 3);
    chk(first_wa == 5 && last_wa == 7, "R6 range prof0", last_wa, 7);
    chk(rd_suspend, "R7 held after burst", rd_suspend, 1);
    pulse_update();
    chk(!rd_suspend, "R8 release", rd_suspend, 0);

    // R4 R6 R8: 256-word segment, prof_sel moved and update pulsed mid-burst
    prof_sel = 2'd1;
    open_frame();
    send_byte(8'h89, 0);
    prof_sel = 2'd0;
    for (int w = 0; w < 256; w++) begin
      send_word(32'hC000_0000 ^ (w * 32'h0101_0101), 0);
      if (w == 100) begin
        io_update = 1'b1;
        @(negedge clk);
        io_update = 1'b0;
        chk(rd_suspend, "R8 update during burst", rd_suspend, 1);
      end
    end
    close_frame();
    chk(n_wr == 256, "R6 count 256..511", n_wr, 256);
    chk(first_wa == 256 && last_wa == 511, "R4 range prof1", last_wa, 511);
    pulse_update();

    // R6 single-word segment
    prof_sel = 2'd2;
    open_frame();
    send_byte(8'h89, 0);
    send_word(32'h0F0F_F0F0, 0);
    send_word(32'h1111_1111, 0);
    close_frame();
    chk(n_wr == 1 && first_wa == 100, "R6 single word", n_wr, 1);
    pulse_update();

    // R9 early frame drop, then a fresh frame
    prof_sel = 2'd3;
    open_frame();
    send_byte(8'h89, 0);
    send_word(32'h7777_0000, 0);
    for (int i = 0; i < 20; i++) send_bit(i[0], 0);
    frame = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_wr == 1, "R9 partial dropped", n_wr, 1);
    open_frame();
    send_byte(8'h89, 0);
    for (int w = 0; w < 4; w++) send_word(32'h5000_0000 + w, 0);
    close_frame();
    chk(n_wr == 4 && first_wa == 1020 && last_wa == 1023, "R9 fresh frame / R4 top", last_wa, 1023);
    pulse_update();
    chk(!rd_suspend, "R8 final release", rd_suspend, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule